// File: doc/BRIEF.md
# SPI Master Transfer Sequencer

This block runs full-duplex SPI transfers as a bus master, one byte at a time. It uses the clock format in which a data bit is launched on the first SCK edge of each bit period and captured on the second. The sequencer does not divide the clock itself. It advances one SCK half-period each time its `tick` input is high for a cycle, so the serial rate is whatever rate the surrounding logic gives the ticks.

Around each byte the sequencer frames the active-low select line with three guard intervals, each at least one tick interval long:

- a lead interval between select assertion and the first SCK edge;
- a trail interval between the last SCK edge and select release;
- an idle interval during which select stays high before a new transfer may begin.

A `start` pulse while a byte is in flight queues one further byte. That byte then follows straight on from the trail interval: select stays low, and neither the lead nor the idle interval is inserted. Each byte ends with a one-cycle `done` pulse, and the captured byte is presented with it.

Top module: `spi_seq_master`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released (with `cpol`=0), the outputs are `ss_n`=1, `sck`=0, `mosi`=0, `done`=0 and `rx_byte`=0.
- R2: A transfer makes exactly 16 SCK edges, one per `tick`, and each appears on the output in the cycle after the tick that causes it. Outside a transfer, SCK does not toggle.
- R3: The SCK rest level equals `cpol` (0: low, 1: high). It follows `cpol` while the sequencer is idle and is held from the cycle a transfer is accepted until that transfer, or its chained successors, have finished.
- R4: `mosi` changes only on odd SCK edges (1, 3, …, 15), in the same cycle as the edge. With `lsb_first`=0 the bits leave in the order 7 down to 0; with `lsb_first`=1 they leave in the order 0 up to 7.
- R5: `miso` is captured on even SCK edges (2, 4, …, 16). The first captured bit lands in `rx_byte` bit 7 when `lsb_first`=0, or in bit 0 when `lsb_first`=1, so a byte sent by the peer in the matching order is reproduced unchanged.
- R6: A `start` seen while idle is accepted: `ss_n` goes low in the next cycle, and `tx_byte` and `lsb_first` are latched. The lead interval ends on the second tick after acceptance, and that tick produces edge 1.
- R7: The first tick after edge 16 ends the trail interval. In the following cycle `done` is high for exactly one cycle, `rx_byte` holds the received byte, and, if no byte is queued, `ss_n` returns high.
- R8: After `ss_n` rises, every `start` is ignored up to and including the cycle of the next tick. Only after that does the sequencer accept a new transfer.
- R9: A `start` while a transfer is in its lead, shifting or trail interval queues `tx_byte` and `lsb_first`. The exception is the cycle whose tick ends the trail interval. Only one byte is held, and further starts are ignored while it waits.
- R10: When the trail interval ends with a byte queued, `ss_n` stays low and the same tick produces edge 1 of the queued byte, in the same cycle as `done` for the finished byte.
- R11: `mosi` keeps the last bit it drove while no transfer is shifting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle enable, once per SCK half-period |
| start | input | 1 | Request a transfer of `tx_byte` |
| tx_byte | input | 8 | Byte to transmit |
| cpol | input | 1 | SCK rest level |
| lsb_first | input | 1 | 1: least significant bit first |
| miso | input | 1 | Serial data from the peer |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peer |
| ss_n | output | 1 | Slave select, active low |
| rx_byte | output | 8 | Last received byte, valid while `done` is high |
| done | output | 1 | One-cycle end-of-byte pulse |

## Verification
The critical coincidence is the end of the trail interval when a byte is queued. In that one cycle the finishing byte raises `done` and delivers `rx_byte`, while the queued byte loads, drives its first `mosi` bit and makes SCK edge 1. The bench provokes this by issuing a second `start` in the middle of a transfer, and also by pseudo-random starts with a tick on every cycle. Some of those random starts fall exactly on the trail-completing tick, where the start must be ignored. A per-cycle reference model judges `sck`, `mosi`, `ss_n`, `done` and `rx_byte`. The bench also confirms that `ss_n` never rises inside a chained burst.

// File: rtl/spi_seq_pkg.sv
// Shared types for the SPI master sequencer.
// Assumes: included in compile order ahead of every sequencer module.
package spi_seq_pkg;

    // Framing phases of one transfer
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_GAP
    } seq_state_t;

endpackage

// File: rtl/spi_seq_shifter.sv
// Combined transmit/receive shift register.
// One register serves both directions. A drive step puts the next
// outgoing bit on MOSI and vacates one end. A sample step writes MISO
// into the vacated end. Order follows the per-byte lsb flag.
// Assumes: drive and sample never occur in the same cycle. A load may
// coincide with a drive, and that drive then uses the incoming byte.
module spi_seq_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         load_lsb,
    input  logic         drive,
    input  logic         sample,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] data
);

    logic [W-1:0] sh;
    logic         lsb_q;
    logic [W-1:0] src;
    logic         lsb_eff;

    // Choose the byte and order a drive step works on
    always_comb begin
        src     = load ? load_data : sh;
        lsb_eff = load ? load_lsb : lsb_q;
    end

    // Shift register, order flag and MOSI output bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            lsb_q <= 1'b0;
            mosi  <= 1'b0;
        end else begin
            if (load) begin
                lsb_q <= load_lsb;
            end
            if (drive) begin
                if (lsb_eff) begin
                    mosi <= src[0];
                    sh   <= {1'b0, src[W-1:1]};
                end else begin
                    mosi <= src[W-1];
                    sh   <= {src[W-2:0], 1'b0};
                end
            end else if (load) begin
                sh <= load_data;
            end else if (sample) begin
                if (lsb_q) begin
                    sh[W-1] <= miso;
                end else begin
                    sh[0] <= miso;
                end
            end
        end
    end

    assign data = sh;

    // R4 R11
    mosi_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> $past(drive));

endmodule

// File: rtl/spi_seq_ctrl.sv
// Framing controller for the SPI master.
// It walks through lead, shift, trail and idle intervals, counting
// SCK edges, and holds at most one queued byte for chaining.
// Assumes: tick is a single-cycle pulse. The caller keeps cpol steady
// in the cycle that start is presented while idle.
module spi_seq_ctrl
    import spi_seq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         start,
    input  logic [W-1:0] tx_byte,
    input  logic         cpol,
    input  logic         lsb_first,
    output logic         sck,
    output logic         ss_n,
    output logic         done,
    output logic         load,
    output logic [W-1:0] load_data,
    output logic         load_lsb,
    output logic         drive,
    output logic         sample,
    output logic         finish
);

    localparam int EDGES = 2 * W;
    localparam int CNT_W = $clog2(EDGES + 1);
    localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES);
    localparam logic [CNT_W-1:0] FIRST_EDGE = CNT_W'(1);

    seq_state_t     state;
    logic           lead_arm;
    logic [CNT_W-1:0] edge_cnt;
    logic [CNT_W-1:0] next_edge;
    logic           ph;
    logic           cpol_q;
    logic           q_valid;
    logic [W-1:0]   q_byte;
    logic           q_lsb;

    logic begin_new, trail_end, chain, lead_go, shift_tick, busy, q_take;

    // Decode this cycle's events from state and tick
    always_comb begin
        next_edge  = edge_cnt + FIRST_EDGE;
        begin_new  = (state == ST_IDLE) && start;
        trail_end  = (state == ST_TRAIL) && tick;
        chain      = trail_end && q_valid;
        lead_go    = (state == ST_LEAD) && tick && lead_arm;
        shift_tick = (state == ST_SHIFT) && tick;
        busy       = (state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_TRAIL);
        q_take     = start && busy && !q_valid && !trail_end;
        load       = begin_new || chain;
        load_data  = chain ? q_byte : tx_byte;
        load_lsb   = chain ? q_lsb : lsb_first;
        drive      = lead_go || chain || (shift_tick && next_edge[0]);
        sample     = shift_tick && !next_edge[0];
        finish     = trail_end;
    end

    // Interval state machine, edge counter and SCK phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lead_arm <= 1'b0;
            edge_cnt <= '0;
            ph       <= 1'b0;
            ss_n     <= 1'b1;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_LEAD;
                        ss_n     <= 1'b0;
                        lead_arm <= 1'b0;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        if (!lead_arm) begin
                            lead_arm <= 1'b1;
                        end else begin
                            state    <= ST_SHIFT;
                            edge_cnt <= FIRST_EDGE;
                            ph       <= 1'b1;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        edge_cnt <= next_edge;
                        ph       <= ~ph;
                        if (next_edge == LAST_EDGE) begin
                            state <= ST_TRAIL;
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        done <= 1'b1;
                        if (q_valid) begin
                            state    <= ST_SHIFT;
                            edge_cnt <= FIRST_EDGE;
                            ph       <= 1'b1;
                        end else begin
                            state <= ST_GAP;
                            ss_n  <= 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Single-entry queue for a byte that chains onto the current one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_byte  <= '0;
            q_lsb   <= 1'b0;
        end else if (chain) begin
            q_valid <= 1'b0;
        end else if (q_take) begin
            q_valid <= 1'b1;
            q_byte  <= tx_byte;
            q_lsb   <= lsb_first;
        end
    end

    // SCK rest level: track cpol while idle, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpol_q <= 1'b0;
        end else if (state == ST_IDLE) begin
            cpol_q <= cpol;
        end
    end

    assign sck = ph ^ cpol_q;

    // R2
    sck_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ph) |-> $past(tick));

    // R3
    sck_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> (ph == 1'b0));

    // R6
    ss_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n) |-> $past(start));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    idle_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) |=> ss_n);

    // R10
    chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain |=> (!ss_n && done));

endmodule

// File: rtl/spi_seq_master.sv
// SPI master transfer sequencer, top level.
// Joins the framing controller and the shift register, and holds the
// received byte at the end of each trail interval.
// Assumes: tick arrives at the SCK half-period rate, and miso is
// stable at the ticks that produce even SCK edges.
module spi_seq_master #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         start,
    input  logic [W-1:0] tx_byte,
    input  logic         cpol,
    input  logic         lsb_first,
    input  logic         miso,
    output logic         sck,
    output logic         mosi,
    output logic         ss_n,
    output logic [W-1:0] rx_byte,
    output logic         done
);

    logic         load, load_lsb, drive, sample, finish;
    logic [W-1:0] load_data;
    logic [W-1:0] sh_data;

    spi_seq_ctrl #(.W(W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start     (start),
        .tx_byte   (tx_byte),
        .cpol      (cpol),
        .lsb_first (lsb_first),
        .sck       (sck),
        .ss_n      (ss_n),
        .done      (done),
        .load      (load),
        .load_data (load_data),
        .load_lsb  (load_lsb),
        .drive     (drive),
        .sample    (sample),
        .finish    (finish)
    );

    spi_seq_shifter #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (load_data),
        .load_lsb  (load_lsb),
        .drive     (drive),
        .sample    (sample),
        .miso      (miso),
        .mosi      (mosi),
        .data      (sh_data)
    );

    // Capture the received byte when the trail interval ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte <= '0;
        end else if (finish) begin
            rx_byte <= sh_data;
        end
    end

    // R5
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rx_byte));

endmodule

// File: tb/spi_seq_master_bench.sv
module spi_seq_master_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       start = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       cpol = 1'b0;
    logic       lsb_first = 1'b0;
    logic       miso = 1'b0;
    logic       sck, mosi, ss_n, done;
    logic [7:0] rx_byte;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    spi_seq_master u_spi_seq_master (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .tx_byte(tx_byte), .cpol(cpol), .lsb_first(lsb_first),
        .miso(miso), .sck(sck), .mosi(mosi), .ss_n(ss_n),
        .rx_byte(rx_byte), .done(done)
    );

    function automatic logic [7:0] peer_byte(input int n);
        return 8'hA5 ^ 8'((n + 1) * 29);
    endfunction

    // ---------------- behavioural reference model ----------------
    // phase: 0 idle, 1 lead, 2 shifting, 3 trail, 4 idle guard
    int         m_phase;
    bit         m_armed;
    int         m_edges;
    bit         m_sck_hi;
    bit         m_cpol;
    bit         m_ss_n;
    bit         m_mosi;
    bit         m_done;
    logic [7:0] m_rx;
    int         m_nbyte;
    bit         m_bits[$];
    logic [8:0] m_pend[$];

    task automatic m_fill(input logic [7:0] b, input bit lsb);
        m_bits.delete();
        for (int i = 0; i < 8; i++) m_bits.push_back(lsb ? b[i] : b[7-i]);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_armed = 0; m_edges = 0; m_sck_hi = 0; m_cpol = 0;
            m_ss_n = 1; m_mosi = 0; m_done = 0; m_rx = 8'h00; m_nbyte = 0;
            m_bits.delete(); m_pend.delete();
        end else begin
            int  old_phase;
            bit  take;
            logic [8:0] nx;
            old_phase = m_phase;
            take = start && (m_pend.size() == 0) && (old_phase >= 1) && (old_phase <= 3)
                   && !(old_phase == 3 && tick);
            m_done = 0;
            if (old_phase == 0) m_cpol = cpol;
            case (old_phase)
                0: if (start) begin
                    m_ss_n = 0; m_phase = 1; m_armed = 0; m_fill(tx_byte, lsb_first);
                end
                1: if (tick) begin
                    if (!m_armed) m_armed = 1;
                    else begin
                        m_edges = 1; m_sck_hi = 1; m_mosi = m_bits.pop_front(); m_phase = 2;
                    end
                end
                2: if (tick) begin
                    m_edges++; m_sck_hi = !m_sck_hi;
                    if (m_edges % 2 == 1) m_mosi = m_bits.pop_front();
                    if (m_edges == 16) m_phase = 3;
                end
                3: if (tick) begin
                    m_done = 1; m_rx = peer_byte(m_nbyte); m_nbyte++;
                    if (m_pend.size() > 0) begin
                        nx = m_pend.pop_front();
                        m_fill(nx[7:0], nx[8]);
                        m_edges = 1; m_sck_hi = 1; m_mosi = m_bits.pop_front(); m_phase = 2;
                    end else begin
                        m_ss_n = 1; m_phase = 4;
                    end
                end
                default: if (tick) m_phase = 0;
            endcase
            if (take) m_pend.push_back({lsb_first, tx_byte});
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // peer side: count SCK edges and present the next bit in the chosen order
    int  p_edges = 0;
    int  p_byte = 0;
    bit  p_prev_sck = 0;
    bit  peer_lsb = 0;
    int  tick_per = 4;
    int  tick_cnt = 0;
    int  ss_rises = 0;
    int  done_seen = 0;
    bit  prev_ss = 1;

    task automatic compare_cycle();
        chk(sck == (m_sck_hi ^ m_cpol), "R2 R3 sck", {7'd0, sck}, {7'd0, m_sck_hi ^ m_cpol});
        chk(ss_n == m_ss_n, "R6 R7 R8 R9 ss_n", {7'd0, ss_n}, {7'd0, m_ss_n});
        chk(mosi == m_mosi, "R4 R11 mosi", {7'd0, mosi}, {7'd0, m_mosi});
        chk(done == m_done, "R7 done", {7'd0, done}, {7'd0, m_done});
        if (m_done) chk(rx_byte == m_rx, "R5 rx_byte", rx_byte, m_rx);
    endtask

    // one clock cycle: judge outputs, update the peer, then drive the next inputs
    task automatic step(input bit st, input logic [7:0] b);
        @(negedge clk);
        compare_cycle();
        if (done) done_seen++;
        if (ss_n && !prev_ss) ss_rises++;
        prev_ss = ss_n;
        if (ss_n) p_edges = 0;
        else if (sck != p_prev_sck) begin
            p_edges = (p_edges + 1) % 16;
            if (p_edges == 0) p_byte++;
        end
        p_prev_sck = sck;
        miso = peer_lsb ? peer_byte(p_byte)[p_edges/2] : peer_byte(p_byte)[7 - p_edges/2];
        start = st;
        tx_byte = b;
        tick_cnt++;
        if (tick_cnt >= tick_per) begin
            tick_cnt = 0; tick = 1;
        end else tick = 0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        int d0, r0;
        logic [15:0] lf;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk(ss_n == 1'b1, "R1 ss_n in reset", {7'd0, ss_n}, 8'h01);
        chk(sck == 1'b0, "R1 sck in reset", {7'd0, sck}, 8'h00);
        chk(done == 1'b0, "R1 done in reset", {7'd0, done}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ss_n == 1'b1 && sck == 1'b0 && mosi == 1'b0, "R1 outputs after reset",
            {5'd0, ss_n, sck, mosi}, 8'h04);
        chk(rx_byte == 8'h00, "R1 rx_byte after reset", rx_byte, 8'h00);

        // single byte, most significant bit first, low rest level
        tick_per = 4; cpol = 0; lsb_first = 0; peer_lsb = 0;
        d0 = done_seen;
        step(1, 8'hC3);
        idle_cycles(120);
        chk(done_seen - d0 == 1, "R7 one done per byte", 8'(done_seen - d0), 8'd1);

        // single byte, least significant bit first, high rest level
        cpol = 1; idle_cycles(3);
        lsb_first = 1; peer_lsb = 1; tick_per = 3;
        step(1, 8'h1E);
        idle_cycles(100);
        chk(sck == 1'b1, "R3 rest level high", {7'd0, sck}, 8'h01);

        // chained bytes: second start mid-transfer, third start ignored
        cpol = 0; idle_cycles(3);
        lsb_first = 0; peer_lsb = 0; tick_per = 2;
        d0 = done_seen; r0 = ss_rises;
        step(1, 8'h96);
        idle_cycles(10);
        step(1, 8'h5A);
        idle_cycles(5);
        step(1, 8'hFF);
        idle_cycles(150);
        chk(done_seen - d0 == 2, "R9 R10 two bytes in burst", 8'(done_seen - d0), 8'd2);
        chk(ss_rises - r0 == 1, "R10 select held across burst", 8'(ss_rises - r0), 8'd1);

        // starts on every cycle right after a byte: guard interval ignores them
        tick_per = 5;
        step(1, 8'h3C);
        for (int i = 0; i < 200; i++) step(1, 8'(i));
        idle_cycles(150);
        chk(ss_n == 1'b1, "R8 select released at end", {7'd0, ss_n}, 8'h01);

        // ticks every cycle with pseudo-random starts, both bit orders
        tick_per = 1; lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] & lf[3], lf[15:8]);
        end
        idle_cycles(60);
        lsb_first = 1; peer_lsb = 1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[1] & lf[5], lf[11:4]);
        end
        idle_cycles(60);
        chk(done_seen > 20, "R7 R9 random traffic completed bytes", 8'(done_seen), 8'd21);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule